// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block watches every input pin of a GPIO bank and turns configured events into latched interrupt status. Each pin has two configuration bits from the register bank, a level-select bit and an invert bit. Together they pick one of four triggers: rising edge, falling edge, low level or high level. Pin inputs first pass through a multi-flop synchroniser. Edges are found by comparing the current synchronised sample with the one from the cycle before. Levels are taken straight from the synchronised sample.

Detected events set bits in status words that are packed `WORD_W` pins per word. Software clears status bits by writing ones to a status word. A matching set of enable words, each written as a whole, gates which pending bits reach the single registered interrupt line. If a new event lands in the same cycle as a clear of its bit, the event wins, so a handler that clears a bit before servicing the pin never misses an edge. A pin can raise status only while it is in GPIO use and its input sensing is on.

Top module: `gpio_irq_detect`

## Requirements
- R1: While `rst_n` is low, `int_status`, `int_enable` and `irq_out` are all 0.
- R2: With `{cfg_level,cfg_invert}` = 2'b00 (rising edge), a 0-to-1 change of the synchronised pin sets that pin's status bit.
- R3: With `{cfg_level,cfg_invert}` = 2'b01 (falling edge), a 1-to-0 change of the synchronised pin sets that pin's status bit.
- R4: With `{cfg_level,cfg_invert}` = 2'b10 (low level), the status bit is set on every cycle in which the synchronised pin is 0, so the bit comes back after a clear while the pin stays low.
- R5: With `{cfg_level,cfg_invert}` = 2'b11 (high level), the status bit is set on every cycle in which the synchronised pin is 1. After the pin drops, a clear leaves the bit at 0.
- R6: A pin whose `cfg_gpio_mode` or `cfg_sense_en` is 0 never sets its status bit.
- R7: A write with `wr_target`=0 (status) to word k clears each status bit whose `wr_data` bit is 1 and keeps each bit whose `wr_data` bit is 0. All ones clears the whole word.
- R8: An event that is detected in the same cycle as a clear of its status bit leaves the bit set.
- R9: A write with `wr_target`=1 (enable) to word k replaces that word's enable bits with `wr_data`. A value of 0 masks every pin in the word. Enable bits do not change without such a write.
- R10: `irq_out` equals the OR over all pins of (status AND enable), as it stood one cycle earlier.
- R11: The status bit for a pin edge goes high on the (`SYNC_STAGES`+1)-th rising clock edge after the change is first sampled.
- R12: Word k covers pins k*`WORD_W` to k*`WORD_W`+`WORD_W`-1, with bit j of `wr_data` mapping to pin k*`WORD_W`+j. A write to one word leaves the other words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NPINS | Raw asynchronous pin levels |
| cfg_level | input | NPINS | Per-pin trigger select: 0 edge, 1 level |
| cfg_invert | input | NPINS | Per-pin invert: selects falling edge or high level |
| cfg_gpio_mode | input | NPINS | Per-pin use select: 1 when the pin is a GPIO |
| cfg_sense_en | input | NPINS | Per-pin input sensing enable |
| wr_en | input | 1 | Word write strobe |
| wr_target | input | 1 | 0 selects status (write-one-to-clear), 1 selects enable |
| wr_idx | input | IDX_W | Word index k |
| wr_data | input | WORD_W | Write data |
| int_status | output | NPINS | Latched interrupt status |
| int_enable | output | NPINS | Per-pin interrupt enable |
| irq_out | output | 1 | Registered combined interrupt |

## Verification
The bench aims at four corner cases. The first is a clear that lands in the exact cycle a rising edge is detected: a design that lets the clear take priority drops the edge and leaves the bit at 0. The second is a level-low pin that is cleared while it is still low: if level mode were treated as a one-shot, the bit would stay clear. The bench also counts the synchroniser latency to the edge, which catches a stage added or removed, and it writes one enable word to check that its neighbour is untouched. Random stretches of pins, modes and writes are run against a behavioural model on every clock, and that model would expose a swapped invert polarity or an unregistered `irq_out`.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   // trigger mode is the pair {level_select, invert}
   typedef enum logic [1:0] {
      TRIG_RISE = 2'b00,
      TRIG_FALL = 2'b01,
      TRIG_LOW  = 2'b10,
      TRIG_HIGH = 2'b11
   } trig_mode_e;

   typedef enum logic {
      TGT_STATUS = 1'b0,
      TGT_ENABLE = 1'b1
   } wr_target_e;

   function automatic logic trig_hit(input logic lvl, input logic inv,
                                     input logic cur, input logic prv);
      trig_mode_e mode;
      mode = trig_mode_e'({lvl, inv});
      case (mode)
         TRIG_RISE: return cur & ~prv;
         TRIG_FALL: return ~cur & prv;
         TRIG_LOW:  return ~cur;
         default:   return cur;
      endcase
   endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("gpio_irq_sync: STAGES must be at least 1");
      end

      if (STAGES == 1) begin : g_single
         logic [W-1:0] stg;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg <= '0;
            else        stg <= d;
         end
         assign q = stg;
      end else begin : g_chain
         logic [W-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < STAGES; s++) stg[s] <= '0;
            end else begin
               stg[0] <= d;
               for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/gpio_irq_trigger.sv
module gpio_irq_trigger
   import gpio_irq_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] smp,
   input  logic [W-1:0] lvl,
   input  logic [W-1:0] inv,
   input  logic [W-1:0] qual,
   output logic [W-1:0] evt
);

   logic [W-1:0] prev_smp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_smp <= '0;
      else        prev_smp <= smp;
   end

   generate
      for (genvar i = 0; i < W; i++) begin : g_pin
         assign evt[i] = qual[i] & trig_hit(lvl[i], inv[i], smp[i], prev_smp[i]);
      end
   endgenerate

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
   import gpio_irq_pkg::*;
#(
   parameter int NPINS  = 40,
   parameter int WORD_W = 32,
   parameter int IDX_W  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NPINS-1:0]  evt,
   input  logic              wr_en,
   input  logic              wr_target,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [WORD_W-1:0] wr_data,
   output logic [NPINS-1:0]  status_q,
   output logic [NPINS-1:0]  enable_q
);

   logic wr_status, wr_enable;
   assign wr_status = wr_en & (wr_target_e'(wr_target) == TGT_STATUS);
   assign wr_enable = wr_en & (wr_target_e'(wr_target) == TGT_ENABLE);

   generate
      for (genvar i = 0; i < NPINS; i++) begin : g_bit
         localparam int WORD = i / WORD_W;
         localparam int BIT  = i % WORD_W;
         logic hit, clr;
         assign hit = (wr_idx == IDX_W'(WORD));
         assign clr = wr_status & hit & wr_data[BIT];

         // detection has priority over a clear in the same cycle
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               status_q[i] <= 1'b0;
               enable_q[i] <= 1'b0;
            end else begin
               status_q[i] <= (status_q[i] & ~clr) | evt[i];
               if (wr_enable && hit) enable_q[i] <= wr_data[BIT];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
   parameter int  NPINS       = 40,
   parameter int  WORD_W      = 32,
   parameter int  SYNC_STAGES = 2,
   localparam int NWORDS      = (NPINS + WORD_W - 1) / WORD_W,
   localparam int IDX_W       = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NPINS-1:0]  pin_in,
   input  logic [NPINS-1:0]  cfg_level,
   input  logic [NPINS-1:0]  cfg_invert,
   input  logic [NPINS-1:0]  cfg_gpio_mode,
   input  logic [NPINS-1:0]  cfg_sense_en,
   input  logic              wr_en,
   input  logic              wr_target,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [WORD_W-1:0] wr_data,
   output logic [NPINS-1:0]  int_status,
   output logic [NPINS-1:0]  int_enable,
   output logic              irq_out
);

   generate
      if (NPINS < 1) begin : g_bad_npins
         $error("gpio_irq_detect: NPINS must be at least 1");
      end
      if (WORD_W < 1) begin : g_bad_word
         $error("gpio_irq_detect: WORD_W must be at least 1");
      end
   endgenerate

   logic [NPINS-1:0] pin_s;
   logic [NPINS-1:0] qual;
   logic [NPINS-1:0] evt;
   logic             irq_q;

   assign qual = cfg_gpio_mode & cfg_sense_en;

   gpio_irq_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s)
   );

   gpio_irq_trigger #(.W(NPINS)) u_trig (
      .clk(clk), .rst_n(rst_n), .smp(pin_s), .lvl(cfg_level),
      .inv(cfg_invert), .qual(qual), .evt(evt)
   );

   gpio_irq_regs #(.NPINS(NPINS), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .evt(evt), .wr_en(wr_en),
      .wr_target(wr_target), .wr_idx(wr_idx), .wr_data(wr_data),
      .status_q(int_status), .enable_q(int_enable)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(int_status & int_enable);
   end

   assign irq_out = irq_q;

endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk #(
   parameter int NPINS  = 40,
   parameter int WORD_W = 32,
   parameter int IDX_W  = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NPINS-1:0]  cfg_gpio_mode,
   input logic [NPINS-1:0]  cfg_sense_en,
   input logic              wr_en,
   input logic              wr_target,
   input logic [IDX_W-1:0]  wr_idx,
   input logic [WORD_W-1:0] wr_data,
   input logic [NPINS-1:0]  int_status,
   input logic [NPINS-1:0]  int_enable,
   input logic              irq_out
);

   logic [NPINS-1:0] clr_vec;
   logic [NPINS-1:0] blocked;

   always_comb begin
      for (int i = 0; i < NPINS; i++) begin
         clr_vec[i] = wr_en && !wr_target && (wr_idx == IDX_W'(i / WORD_W))
                      && wr_data[i % WORD_W];
      end
   end

   assign blocked = ~(cfg_gpio_mode & cfg_sense_en);

   // R10: combined line follows gated status one cycle later
   p_irq_lag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (irq_out == $past(|(int_status & int_enable))));

   // R7: a pending bit survives unless its clear bit was written
   p_keep_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> ((($past(int_status) & ~$past(clr_vec)) & ~int_status) == '0));

   // R9: enables move only on an enable write
   p_enable_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_target) |=> $stable(int_enable));

   // R6: a pin that cannot sense never turns its status on
   p_blocked_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> ((($past(~int_status & blocked)) & int_status) == '0));

endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(
   .NPINS(NPINS), .WORD_W(WORD_W), .IDX_W(IDX_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_gpio_mode(cfg_gpio_mode),
   .cfg_sense_en(cfg_sense_en), .wr_en(wr_en), .wr_target(wr_target),
   .wr_idx(wr_idx), .wr_data(wr_data), .int_status(int_status),
   .int_enable(int_enable), .irq_out(irq_out)
);

// File: tb/gpio_irq_detect_test.sv
module gpio_irq_detect_test;

   localparam int CLK_PERIOD = 10;
   localparam int N   = 40;
   localparam int WW  = 32;
   localparam int SYN = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  pin = '0, lvl = '0, inv = '0, isg = '0, sen = '0;
   logic          wr_en = 1'b0, wr_target = 1'b0;
   logic [0:0]    wr_idx = '0;
   logic [WW-1:0] wr_data = '0;
   logic [N-1:0]  st, en;
   logic          irq;

   int    n_checks = 0;
   int    n_fails  = 0;
   bit    done = 1'b0;
   string cur_req = "R1";

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_irq_detect #(.NPINS(N), .WORD_W(WW), .SYNC_STAGES(SYN)) uut (
      .clk(clk), .rst_n(rst_n), .pin_in(pin), .cfg_level(lvl),
      .cfg_invert(inv), .cfg_gpio_mode(isg), .cfg_sense_en(sen),
      .wr_en(wr_en), .wr_target(wr_target), .wr_idx(wr_idx),
      .wr_data(wr_data), .int_status(st), .int_enable(en), .irq_out(irq)
   );

   // behavioural reference model
   logic [N-1:0] m_st = '0, m_en = '0, m_prev = '0;
   logic         m_irq = 1'b0;
   logic [N-1:0] m_pipe[$];

   initial begin
      for (int k = 0; k < SYN; k++) m_pipe.push_back('0);
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = '0; m_en = '0; m_prev = '0; m_irq = 1'b0;
         m_pipe.delete();
         for (int k = 0; k < SYN; k++) m_pipe.push_back('0);
      end else begin
         logic [N-1:0] cur, ev, clr;
         logic         nirq;
         cur = m_pipe[0];
         for (int i = 0; i < N; i++) begin
            bit hit;
            if (!lvl[i]) hit = inv[i] ? (!cur[i] && m_prev[i]) : (cur[i] && !m_prev[i]);
            else         hit = inv[i] ? cur[i] : !cur[i];
            ev[i]  = hit && isg[i] && sen[i];
            clr[i] = wr_en && !wr_target && (int'(wr_idx) == i / WW) && wr_data[i % WW];
         end
         nirq = |(m_st & m_en);
         m_st = (m_st & ~clr) | ev;
         for (int i = 0; i < N; i++)
            if (wr_en && wr_target && (int'(wr_idx) == i / WW)) m_en[i] = wr_data[i % WW];
         m_irq  = nirq;
         m_prev = cur;
         void'(m_pipe.pop_front());
         m_pipe.push_back(pin);
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         n_checks++;
         if (st !== m_st) begin
            n_fails++;
            $display("FAIL %s status act=%h exp=%h", cur_req, st, m_st);
         end
         n_checks++;
         if (en !== m_en) begin
            n_fails++;
            $display("FAIL %s enable act=%h exp=%h", cur_req, en, m_en);
         end
         n_checks++;
         if (irq !== m_irq) begin
            n_fails++;
            $display("FAIL R10 irq (%s) act=%b exp=%b", cur_req, irq, m_irq);
         end
      end
   end

   task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic tgt, input int idx, input logic [WW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_target = tgt; wr_idx = idx[0:0]; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic clear_all();
      wr(1'b0, 0, '1);
      wr(1'b0, 1, '1);
   endtask

   initial begin
      for (int i = 0; i < N; i++) begin
         lvl[i] = (i % 4) >= 2;
         inv[i] = (i % 2) == 1;
      end
      isg = '1; sen = '1;
      isg[4] = 1'b0;
      sen[8] = 1'b0;
      idle(3);
      cur_req = "R1";
      chk("R1 status in reset", st, '0);
      chk("R1 enable in reset", en, '0);
      chk("R1 irq in reset", {{(N-1){1'b0}}, irq}, '0);
      rst_n = 1'b1;

      // enables, word addressing
      cur_req = "R9";
      wr(1'b1, 0, '1);
      wr(1'b1, 1, '1);
      chk("R9 enable all ones", en, {N{1'b1}});
      cur_req = "R12";
      wr(1'b1, 1, '0);
      chk("R12 word1 masked, word0 kept", en, {{(N-WW){1'b0}}, {WW{1'b1}}});
      idle(2);
      cur_req = "R10";
      chk("R10 irq from low-level pins", {{(N-1){1'b0}}, irq}, 1);

      // all pins rising, clean slate
      cur_req = "R7";
      lvl = '0; inv = '0;
      idle(4);
      clear_all();
      chk("R7 all ones clears", st, '0);

      cur_req = "R2";
      pin[1] = 1'b1; pin[4] = 1'b1; pin[8] = 1'b1; pin[3] = 1'b1;
      idle(4);
      chk("R2 rising sets bits 1,3", st, 40'h0A);
      chk("R6 gated pins 4,8 quiet", st & 40'h110, '0);

      cur_req = "R7";
      wr(1'b0, 0, 32'h2);
      chk("R7 partial clear keeps bit3", st, 40'h08);
      clear_all();

      cur_req = "R3";
      inv = '1;
      idle(2);
      pin[1] = 1'b0;
      idle(4);
      chk("R3 falling sets bit1", st, 40'h02);
      inv = '0;
      idle(2);
      clear_all();

      // same-cycle event and clear
      cur_req = "R8";
      @(negedge clk); pin[0] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      wr_en = 1'b1; wr_target = 1'b0; wr_idx = '0; wr_data = 32'h1;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
      chk("R8 event beats clear", st & 40'h1, 40'h1);
      @(negedge clk); pin[2] = 1'b1;
      idle(3);
      wr(1'b0, 0, 32'h4);
      chk("R7 late clear removes bit2", st & 40'h4, '0);

      // latency
      cur_req = "R11";
      clear_all();
      @(negedge clk); pin[20] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk("R11 not yet after two edges", st & (40'h1 << 20), '0);
      @(negedge clk);
      chk("R11 set on third edge", st & (40'h1 << 20), 40'h1 << 20);

      // irq follows enable with one cycle lag
      cur_req = "R10";
      idle(1);
      wr(1'b1, 0, '0);
      chk("R10 irq still high one cycle", {{(N-1){1'b0}}, irq}, 1);
      @(negedge clk);
      chk("R10 irq drops after mask", {{(N-1){1'b0}}, irq}, 0);
      wr(1'b1, 0, '1);

      // level modes
      cur_req = "R4";
      pin = '0;
      lvl = '1; inv = '0;
      idle(4);
      clear_all();
      idle(1);
      chk("R4 low level reasserts", st & (40'h1 << 10), 40'h1 << 10);
      cur_req = "R5";
      inv = '1;
      pin[10] = 1'b1;
      idle(4);
      clear_all();
      idle(1);
      chk("R5 high level reasserts", st & (40'h1 << 10), 40'h1 << 10);
      pin[10] = 1'b0;
      idle(4);
      clear_all();
      idle(1);
      chk("R5 clear sticks once low", st & (40'h1 << 10), '0);

      // random stretch against the model
      cur_req = "R2/R3/R4/R5/R7/R8 random";
      for (int c = 0; c < 3000; c++) begin
         @(negedge clk);
         pin = {$urandom, $urandom};
         if (c % 50 == 0) begin
            lvl = {$urandom, $urandom};
            inv = {$urandom, $urandom};
            isg = {$urandom, $urandom} | {$urandom, $urandom};
            sen = {$urandom, $urandom} | {$urandom, $urandom};
         end
         wr_en     = ($urandom % 3) == 0;
         wr_target = ($urandom % 4) == 0;
         wr_idx    = 1'($urandom);
         wr_data   = $urandom;
      end
      @(negedge clk);
      wr_en = 1'b0;
      idle(2);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fails++;
         $display("FAIL watchdog (%s) act=running exp=finished", cur_req);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

endmodule